// File: doc/BRIEF.md
# Single-cycle subset processor core

A 32-bit processor core that finishes one instruction in every clock cycle. It executes seven instructions: register add and subtract, add-immediate, word load, word store, branch-if-equal and absolute jump. The core holds the program counter, a 32-entry register file, the immediate sign extender, a two-function ALU, the operand and write-back multiplexers, and the next-address logic.

Instruction and data storage sit outside the core. The core puts out the fetch address and receives the instruction word back in the same cycle. For data it drives an address, write data and a write enable, and it receives load data in the same cycle. Stores are committed by the external memory on the rising clock edge. Because each instruction completes within its own cycle, there is no stall, hazard or sequencing logic.

Top module: `sc_core`

## Requirements
- R1: While `rst_ni` is low the fetch address is 0, and the first instruction after release is fetched from address 0.
- R2: Register instructions use opcode 0x00, with funct 0x20 for add and funct 0x22 for subtract. The fields are opcode [31:26], first source [25:21], second source [20:16], destination [15:11] and funct [5:0]. The destination receives the sum or the difference (first minus second) of the two sources, modulo 2^32.
- R3: Add-immediate (opcode 0x08) writes the register in [20:16] with the register in [25:21] plus the sign-extended 16-bit immediate in [15:0].
- R4: Load (0x23) and store (0x2B) use the byte address base [25:21] plus the sign-extended immediate. A load writes the returned word to register [20:16]. A store drives register [20:16] onto the write data with the write enable high and leaves every register unchanged.
- R5: Branch-if-equal (0x04) moves to PC+4+(sign-extended immediate × 4) when its two source registers are equal, including negative offsets, and to PC+4 otherwise. Every instruction other than branch and jump moves to PC+4.
- R6: Jump (0x02) loads the PC with bits [31:28] of the current PC, then the 26-bit target in [25:0], then two zero bits.
- R7: Register 0 reads as zero, and writes to it have no effect.
- R8: Any other opcode, and any register instruction whose funct is neither add nor subtract, writes neither a register nor memory and moves to PC+4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | 32 | Fetch byte address (current PC) |
| imem_data_i | input | 32 | Instruction word at imem_addr_o, same cycle |
| dmem_addr_o | output | 32 | Data byte address |
| dmem_wdata_o | output | 32 | Store data |
| dmem_we_o | output | 1 | Store enable, committed on the rising edge |
| dmem_rdata_i | input | 32 | Load data at dmem_addr_o, same cycle |

## Verification
The properties assume that the instruction port returns a defined word for the current fetch address within the same cycle. They also assume that load data follows the data address combinationally, so that each retired instruction fully determines the next PC. The stimulus holds to this with a harness that answers both memories from small word arrays indexed by address bits [7:2]. The program keeps every data address word-aligned and inside those arrays, and it releases reset only on a falling clock edge.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int unsigned XLEN    = 32;
  localparam int unsigned NREG    = 32;
  localparam int unsigned RAW     = $clog2(NREG);
  localparam int unsigned IMM_W   = 16;
  localparam int unsigned TGT_W   = 26;

  localparam logic [5:0] OP_REG  = 6'h00;
  localparam logic [5:0] OP_ADDI = 6'h08;
  localparam logic [5:0] OP_LOAD = 6'h23;
  localparam logic [5:0] OP_STOR = 6'h2B;
  localparam logic [5:0] OP_BEQ  = 6'h04;
  localparam logic [5:0] OP_JMP  = 6'h02;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_SUB  = 6'h22;

  typedef enum logic {ALU_ADD = 1'b0, ALU_SUB = 1'b1} alu_fn_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_rd;
    logic    use_imm;
    logic    wb_mem;
    logic    mem_we;
    logic    branch;
    logic    jump;
    alu_fn_e alu_fn;
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o        = '0;
    ctrl_o.alu_fn = ALU_ADD;
    case (op_i)
      OP_REG: begin
        if (funct_i == FN_ADD || funct_i == FN_SUB) begin
          ctrl_o.reg_we = 1'b1;
          ctrl_o.dst_rd = 1'b1;
          ctrl_o.alu_fn = (funct_i == FN_SUB) ? ALU_SUB : ALU_ADD;
        end
      end
      OP_ADDI: begin
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.use_imm = 1'b1;
      end
      OP_LOAD: begin
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.use_imm = 1'b1;
        ctrl_o.wb_mem  = 1'b1;
      end
      OP_STOR: begin
        ctrl_o.mem_we  = 1'b1;
        ctrl_o.use_imm = 1'b1;
      end
      OP_BEQ: begin
        ctrl_o.branch = 1'b1;
        ctrl_o.alu_fn = ALU_SUB;
      end
      OP_JMP:  ctrl_o.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int unsigned DW   = 32,
  parameter int unsigned NREG = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_a_i,
  input  logic [AW-1:0] ra_b_i,
  output logic [DW-1:0] rd_a_o,
  output logic [DW-1:0] rd_b_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [DW-1:0] wd_i
);
  logic [DW-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NREG); i++) regs_q[i] <= '0;
    end else if (we_i && wa_i != '0) begin
      regs_q[wa_i] <= wd_i;
    end
  end

  // entry 0 is hard zero on read
  assign rd_a_o = (ra_a_i == '0) ? '0 : regs_q[ra_a_i];
  assign rd_b_o = (ra_b_i == '0) ? '0 : regs_q[ra_b_i];
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  alu_fn_e       fn_i,
  output logic [DW-1:0] y_o,
  output logic          zero_o
);
  always_comb begin
    case (fn_i)
      ALU_SUB: y_o = a_i - b_i;
      default: y_o = a_i + b_i;
    endcase
  end
  assign zero_o = (y_o == '0);
endmodule

// File: rtl/sc_pc.sv
module sc_pc #(
  parameter int unsigned DW    = 32,
  parameter int unsigned TGT_W = 26
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             branch_i,
  input  logic             zero_i,
  input  logic             jump_i,
  input  logic [DW-1:0]    imm_i,
  input  logic [TGT_W-1:0] tgt_i,
  output logic [DW-1:0]    pc_o
);
  localparam int unsigned HI_W = DW - TGT_W - 2;

  logic [DW-1:0] pc_q, pc_inc, pc_br, pc_jmp, pc_d;

  assign pc_inc = pc_q + DW'(4);
  assign pc_br  = pc_inc + {imm_i[DW-3:0], 2'b00};
  assign pc_jmp = {pc_q[DW-1 -: HI_W], tgt_i, 2'b00};

  always_comb begin
    if (jump_i)                pc_d = pc_jmp;
    else if (branch_i && zero_i) pc_d = pc_br;
    else                       pc_d = pc_inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] imem_addr_o,
  input  logic [XLEN-1:0] imem_data_i,
  output logic [XLEN-1:0] dmem_addr_o,
  output logic [XLEN-1:0] dmem_wdata_o,
  output logic            dmem_we_o,
  input  logic [XLEN-1:0] dmem_rdata_i
);
  logic [5:0]       op, funct;
  logic [RAW-1:0]   rs, rt, rd, dst;
  logic [IMM_W-1:0] imm16;
  logic [TGT_W-1:0] tgt;
  logic [XLEN-1:0]  imm_ext, rs_data, rt_data, alu_b, alu_y, wb_data;
  logic             alu_zero, rf_we;
  logic             unused_shamt;
  ctrl_t            ctrl;

  assign op           = imem_data_i[31:26];
  assign rs           = imem_data_i[25:21];
  assign rt           = imem_data_i[20:16];
  assign rd           = imem_data_i[15:11];
  assign funct        = imem_data_i[5:0];
  assign imm16        = imem_data_i[IMM_W-1:0];
  assign tgt          = imem_data_i[TGT_W-1:0];
  assign unused_shamt = ^imem_data_i[10:6];

  sc_decode u_dec (
    .op_i   (op),
    .funct_i(funct),
    .ctrl_o (ctrl)
  );

  assign imm_ext = {{(XLEN-IMM_W){imm16[IMM_W-1]}}, imm16};
  assign dst     = ctrl.dst_rd ? rd : rt;
  assign rf_we   = ctrl.reg_we;
  assign wb_data = ctrl.wb_mem ? dmem_rdata_i : alu_y;

  sc_regfile #(.DW(XLEN), .NREG(NREG)) u_rf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ra_a_i(rs),
    .ra_b_i(rt),
    .rd_a_o(rs_data),
    .rd_b_o(rt_data),
    .we_i  (rf_we),
    .wa_i  (dst),
    .wd_i  (wb_data)
  );

  assign alu_b = ctrl.use_imm ? imm_ext : rt_data;

  sc_alu #(.DW(XLEN)) u_alu (
    .a_i   (rs_data),
    .b_i   (alu_b),
    .fn_i  (ctrl.alu_fn),
    .y_o   (alu_y),
    .zero_o(alu_zero)
  );

  sc_pc #(.DW(XLEN), .TGT_W(TGT_W)) u_pc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .branch_i(ctrl.branch),
    .zero_i  (alu_zero),
    .jump_i  (ctrl.jump),
    .imm_i   (imm_ext),
    .tgt_i   (tgt),
    .pc_o    (imem_addr_o)
  );

  assign dmem_addr_o  = alu_y;
  assign dmem_wdata_o = rt_data;
  assign dmem_we_o    = ctrl.mem_we;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] instr_i,
  input logic            dmem_we_i,
  input logic            rf_we_i,
  input logic [RAW-1:0]  rs_i,
  input logic [XLEN-1:0] rs_data_i,
  input logic [XLEN-1:0] rt_data_i
);
  logic [5:0] op;
  logic       known;
  assign op    = instr_i[31:26];
  assign known = (op == OP_REG && (instr_i[5:0] == FN_ADD || instr_i[5:0] == FN_SUB)) ||
                 op == OP_ADDI || op == OP_LOAD || op == OP_STOR ||
                 op == OP_BEQ  || op == OP_JMP;

  a_r1_reset_pc: assert property (@(posedge clk_i) !rst_ni |-> pc_i == '0);

  a_r5_pc_seq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op != OP_BEQ && op != OP_JMP) |=> pc_i == $past(pc_i) + XLEN'(4));

  a_r5_beq_fallthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_BEQ && rs_data_i != rt_data_i) |=> pc_i == $past(pc_i) + XLEN'(4));

  a_r6_jump_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op == OP_JMP |=> (pc_i[27:0] == {$past(instr_i[25:0]), 2'b00}) &&
                     (pc_i[XLEN-1:28] == $past(pc_i[XLEN-1:28])));

  a_r7_zero_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_i == '0 |-> rs_data_i == '0);

  a_r4_store_no_regwrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op == OP_STOR |-> dmem_we_i && !rf_we_i);

  a_r8_unknown_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !known |-> !dmem_we_i && !rf_we_i);
endmodule

bind sc_core sc_core_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pc_i     (imem_addr_o),
  .instr_i  (imem_data_i),
  .dmem_we_i(dmem_we_o),
  .rf_we_i  (rf_we),
  .rs_i     (rs),
  .rs_data_i(rs_data),
  .rt_data_i(rt_data)
);

// File: tb/sc_core_test.sv
module sc_core_test;
  localparam int NPROG  = 23;
  localparam int NSTEP  = 23;
  localparam int MWORDS = 64;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_j(int tgt);
    return {6'h02, 26'(tgt)};
  endfunction

  typedef struct packed {
    logic [31:0] pc;
    logic        we;
    logic [31:0] addr;
    logic [31:0] wdata;
  } step_t;

  function automatic step_t st(int pc, logic we, int addr, int wd);
    return '{pc: 32'(pc), we: we, addr: 32'(addr), wdata: 32'(wd)};
  endfunction

  localparam logic [31:0] FILL = enc_i(6'h2B, 0, 1, 0);

  localparam logic [31:0] PROG [NPROG] = '{
    enc_i(6'h08, 0, 1, 5),   enc_i(6'h08, 0, 2, -3),
    enc_r(1, 2, 3, 6'h20),   enc_r(2, 1, 4, 6'h22),
    enc_i(6'h2B, 0, 3, 8),   enc_i(6'h2B, 1, 4, 7),
    enc_i(6'h23, 0, 5, 8),   enc_i(6'h08, 0, 0, 7),
    enc_i(6'h2B, 0, 0, 16),  enc_i(6'h04, 3, 5, 2),
    FILL, FILL,
    enc_i(6'h04, 1, 2, 5),   enc_j(16),
    FILL, FILL,
    enc_i(6'h08, 6, 6, 1),   enc_i(6'h2B, 0, 6, 20),
    enc_i(6'h04, 6, 3, 1),   enc_i(6'h04, 0, 0, -4),
    32'hFC00_0000,           enc_i(6'h2B, 0, 5, 24),
    enc_j(22)
  };

  localparam step_t TRACE [NSTEP] = '{
    st(0, 0, 0, 0),   st(4, 0, 0, 0),   st(8, 0, 0, 0),   st(12, 0, 0, 0),
    st(16, 1, 8, 2),  st(20, 1, 12, -8), st(24, 0, 0, 0), st(28, 0, 0, 0),
    st(32, 1, 16, 0), st(36, 0, 0, 0),  st(48, 0, 0, 0),  st(52, 0, 0, 0),
    st(64, 0, 0, 0),  st(68, 1, 20, 1), st(72, 0, 0, 0),  st(76, 0, 0, 0),
    st(64, 0, 0, 0),  st(68, 1, 20, 2), st(72, 0, 0, 0),  st(80, 0, 0, 0),
    st(84, 1, 24, 2), st(88, 0, 0, 0),  st(88, 0, 0, 0)
  };

  function automatic string step_req(int i);
    case (i)
      0:                      return "R1";
      1, 2:                   return "R3";
      3, 4, 5:                return "R2";
      6, 7:                   return "R4";
      8, 9:                   return "R7";
      12, 22:                 return "R6";
      20, 21:                 return "R8";
      default:                return "R5";
    endcase
  endfunction

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;
  logic [31:0] imem [MWORDS];
  logic [31:0] dmem [MWORDS];
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  sc_core uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .imem_addr_o (imem_addr),
    .imem_data_i (imem_data),
    .dmem_addr_o (dmem_addr),
    .dmem_wdata_o(dmem_wdata),
    .dmem_we_o   (dmem_we),
    .dmem_rdata_i(dmem_rdata)
  );

  assign imem_data  = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MWORDS; i++) begin
      imem[i] = (i < NPROG) ? PROG[i] : 32'h0;
      dmem[i] = 32'h0;
    end
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "pc in reset", imem_addr, 32'h0);
    chk("R1", "we in reset", {31'h0, dmem_we}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NSTEP; i++) begin
      chk(step_req(i), $sformatf("pc step %0d", i), imem_addr, TRACE[i].pc);
      chk(step_req(i), $sformatf("we step %0d", i), {31'h0, dmem_we}, {31'h0, TRACE[i].we});
      if (TRACE[i].we) begin
        chk(step_req(i), $sformatf("addr step %0d", i), dmem_addr, TRACE[i].addr);
        chk(step_req(i), $sformatf("wdata step %0d", i), dmem_wdata, TRACE[i].wdata);
      end
      @(negedge clk);
    end

    // R6: self-jump holds
    chk("R6", "self jump", imem_addr, 32'd88);
    // R4: stored words landed at the expected addresses
    chk("R4", "mem word 2", dmem[2], 32'd2);
    chk("R4", "mem word 3", dmem[3], 32'hFFFF_FFF8);
    chk("R7", "mem word 4", dmem[4], 32'h0);
    chk("R5", "mem word 5", dmem[5], 32'd2);

    // R1: asynchronous reset mid-run
    #3 rst_n = 1'b0;
    #2 chk("R1", "pc async reset", imem_addr, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "pc after release", imem_addr, 32'h0);
    @(negedge clk);
    chk("R1", "pc one after release", imem_addr, 32'd4);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule